// File: doc/BRIEF.md
# Hard Reset Sequencer

This block is the controller-side sequencer that walks a USB power-delivery port through a hard reset or a cable reset. A reset starts in one of three ways: the policy layer asks for one, the port controller raises its hard-reset-received alert, or the controller reports a cable reset in its receive status together with the receive-status alert. The sequencer first zeroes the protocol layer's message ID counter. It then branches on who started the reset. A locally started reset asks the physical side to send the reset signalling, waits for the physical side to report completion, and tells the policy layer the request went out. A reset started by the port partner or the cable is reported to the policy layer as received.

Both branches then wait for the policy layer to report that its own reset work is finished. To close the sequence, the block writes a clear to the modem-related alert bits and then writes a non-zero receive-detect value to turn the receiver back on. A watchdog limits the wait for the physical side. If it expires, the sequence goes straight to the policy-completion wait and raises an error flag. While any reset step is in progress, a busy output holds off other transmit and receive processing.

Top module: `hrst_seq`

## Requirements
- R1: After a synchronous active-low reset, every strobe is low, `busy`, `seq_err`, `rst_local` and `rst_is_cable` are low, and `alert_clr_mask` and `rxdet_val` are zero.
- R2: When idle, any of three triggers starts a sequence: `pe_hr_req`, alert bit 1 (hard reset received), or alert bit 0 (receive status) together with `rx_cable`. `rx_cable` without alert bit 0 does nothing. One cycle after the trigger, `msgid_clr` is high for exactly one cycle and `busy` is high.
- R3: For a policy-layer request, the cycle after `msgid_clr` carries a one-cycle `tx_wr` with `rst_local`=1. `rst_is_cable` equals `pe_cable` as sampled with the request.
- R4: The physical side is complete only when alert bits 6 (transmit success) and 4 (transmit failed) are high in the same cycle; either bit alone does not complete it. The cycle after completion carries a one-cycle `pe_sent_ind`.
- R5: For a reset received from the partner or the cable, the cycle after `msgid_clr` carries a one-cycle `pe_rcvd_ind` with `rst_local`=0, and no `tx_wr` is issued. `rst_is_cable` is 1 only for the cable trigger.
- R6: `pe_done` is accepted only in the policy-completion wait. In any other state it has no effect.
- R7: The cycle after `pe_done` is accepted, `alert_clr_wr` pulses for one cycle. At the same time, `alert_clr_mask` has exactly bits 0, 1, 4, 5, 6 and 10 set (receive status, hard reset, transmit failed, transmit discarded, transmit success, receive buffer full). The next cycle pulses `rxdet_wr` with `rxdet_val` equal to the non-zero `RXDET_EN`, and the cycle after that is idle.
- R8: If the physical side has not completed after `WDOG_CYC` cycles of waiting, the sequence moves to the policy-completion wait with `seq_err`=1 and no `pe_sent_ind`. A completion seen in the last waiting cycle still counts as a success. `seq_err` stays set until the next trigger clears it.
- R9: `busy` is high in every cycle from `msgid_clr` through `rxdet_wr`. Triggers that arrive while busy are ignored.
- R10: When triggers coincide, the hard-reset alert takes priority over the cable receive status, and the cable receive status takes priority over a policy-layer request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_hr_req | input | 1 | Policy layer asks for a reset (strobe) |
| pe_cable | input | 1 | With the request: 1 for cable reset, 0 for hard reset |
| pe_done | input | 1 | Policy layer reports its reset work complete (strobe) |
| alert_in | input | ALERT_W | Current alert register image |
| rx_cable | input | 1 | Receive status reports a cable reset |
| busy | output | 1 | Sequence in progress; hold off other traffic |
| seq_err | output | 1 | Last physical-side wait ended by watchdog |
| rst_local | output | 1 | Current/last sequence was locally started |
| rst_is_cable | output | 1 | Current/last sequence is a cable reset |
| msgid_clr | output | 1 | Zero the message ID counter (strobe) |
| tx_wr | output | 1 | Write the transmit register to send the reset (strobe) |
| pe_sent_ind | output | 1 | Tell the policy layer the reset was sent (strobe) |
| pe_rcvd_ind | output | 1 | Tell the policy layer a reset was received (strobe) |
| alert_clr_wr | output | 1 | Write-one-to-clear of the alert register (strobe) |
| alert_clr_mask | output | ALERT_W | Bits cleared by that write |
| rxdet_wr | output | 1 | Write the receive-detect register (strobe) |
| rxdet_val | output | RXDET_W | Value written to receive detect |

## Verification
Two pairs of events can land in the same cycle. The first is physical-side completion and watchdog expiry. The bench raises both transmit alerts exactly in the last permitted waiting cycle and expects success with no error. It then raises them one cycle later and expects the error path with no sent indication. The second pair is a policy request that arrives together with a received hard-reset alert or cable status. Here the bench expects the received branch, with no transmit write. A behavioural model predicts every output on every cycle, so a wrong priority or an off-by-one window shows up as a mismatch in the cycle where it happens.

// File: rtl/hrst_pkg.sv
// Shared definitions for the hard reset sequencer.
// Assumes the alert register image is at least 11 bits wide.
package hrst_pkg;

    // Alert bit positions the sequencer reads or clears
    localparam int AL_RXSTAT  = 0;
    localparam int AL_HARDRST = 1;
    localparam int AL_TXFAIL  = 4;
    localparam int AL_TXDISC  = 5;
    localparam int AL_TXOK    = 6;
    localparam int AL_RXFULL  = 10;

    // Sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_LAYER,
        S_REQTX,
        S_WAITPHY,
        S_SENT,
        S_INDICATE,
        S_WAITPE,
        S_CLEAR,
        S_RXEN
    } hrs_state_e;

endpackage

// File: rtl/hrst_trig.sv
// Trigger arbitration for the hard reset sequencer.
// Combinational; decides whether a sequence starts this cycle, which
// branch it takes and whether it is a cable reset. Priority: received
// hard reset, then received cable reset, then a policy request.
module hrst_trig (
    input  logic al_hard,
    input  logic al_rxstat,
    input  logic rx_cable,
    input  logic pe_hr_req,
    input  logic pe_cable,
    output logic start,
    output logic from_local,
    output logic is_cable
);

    logic cable_seen;

    // Cable reset counts only when the receive-status alert is up
    assign cable_seen = al_rxstat & rx_cable;

    // Priority choice between the three triggers
    always_comb begin
        start      = al_hard | cable_seen | pe_hr_req;
        from_local = 1'b0;
        is_cable   = 1'b0;
        if (al_hard) begin
            is_cable = 1'b0;
        end else if (cable_seen) begin
            is_cable = 1'b1;
        end else if (pe_hr_req) begin
            from_local = 1'b1;
            is_cable   = pe_cable;
        end
    end

endmodule

// File: rtl/hrst_wdog.sv
// Watchdog for the physical-side completion wait.
// Counts cycles while run is high and clears whenever run is low;
// expired is high in the WDOG_CYC-th consecutive cycle of run.
module hrst_wdog #(
    parameter int WDOG_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(WDOG_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_CYC - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    // Cycle counter over the waiting window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hrst_outdec.sv
// Output decode for the hard reset sequencer.
// Turns the state register into one-cycle strobes, the busy level and
// the values that go with the two register writes. Purely combinational.
module hrst_outdec
    import hrst_pkg::*;
#(
    parameter int                  ALERT_W  = 16,
    parameter int                  RXDET_W  = 8,
    parameter logic [RXDET_W-1:0]  RXDET_EN = 'h21
) (
    input  hrs_state_e          state,
    output logic                busy,
    output logic                msgid_clr,
    output logic                tx_wr,
    output logic                pe_sent_ind,
    output logic                pe_rcvd_ind,
    output logic                alert_clr_wr,
    output logic [ALERT_W-1:0]  alert_clr_mask,
    output logic                rxdet_wr,
    output logic [RXDET_W-1:0]  rxdet_val
);

    logic [ALERT_W-1:0] clr_bits;

    // Modem-related alert bits cleared at the end of a sequence
    always_comb begin
        clr_bits             = '0;
        clr_bits[AL_RXSTAT]  = 1'b1;
        clr_bits[AL_HARDRST] = 1'b1;
        clr_bits[AL_TXFAIL]  = 1'b1;
        clr_bits[AL_TXDISC]  = 1'b1;
        clr_bits[AL_TXOK]    = 1'b1;
        clr_bits[AL_RXFULL]  = 1'b1;
    end

    // Strobe and level decode from the current state
    always_comb begin
        busy         = (state != S_IDLE);
        msgid_clr    = (state == S_LAYER);
        tx_wr        = (state == S_REQTX);
        pe_sent_ind  = (state == S_SENT);
        pe_rcvd_ind  = (state == S_INDICATE);
        alert_clr_wr = (state == S_CLEAR);
        rxdet_wr     = (state == S_RXEN);
        alert_clr_mask = alert_clr_wr ? clr_bits : '0;
        rxdet_val      = rxdet_wr ? RXDET_EN : '0;
    end

endmodule

// File: rtl/hrst_seq.sv
// Hard / cable reset sequencer, controller side.
// Starts on a policy request or a received reset alert, clears the
// message ID counter, sends or reports the reset, waits for the physical
// side (local case, watchdog-limited) and the policy layer, then clears
// modem alerts and re-enables the receiver. Assumes alert_in is the live
// alert image and that completion strobes are single-cycle.
module hrst_seq
    import hrst_pkg::*;
#(
    parameter int                  ALERT_W  = 16,
    parameter int                  WDOG_CYC = 64,
    parameter int                  RXDET_W  = 8,
    parameter logic [RXDET_W-1:0]  RXDET_EN = 'h21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pe_hr_req,
    input  logic                pe_cable,
    input  logic                pe_done,
    input  logic [ALERT_W-1:0]  alert_in,
    input  logic                rx_cable,
    output logic                busy,
    output logic                seq_err,
    output logic                rst_local,
    output logic                rst_is_cable,
    output logic                msgid_clr,
    output logic                tx_wr,
    output logic                pe_sent_ind,
    output logic                pe_rcvd_ind,
    output logic                alert_clr_wr,
    output logic [ALERT_W-1:0]  alert_clr_mask,
    output logic                rxdet_wr,
    output logic [RXDET_W-1:0]  rxdet_val
);

    hrs_state_e state, state_nx;
    logic       trig_start, trig_local, trig_cable;
    logic       wd_expired;
    logic       phy_done;

    assign phy_done = alert_in[AL_TXOK] & alert_in[AL_TXFAIL];

    hrst_trig u_trig (
        .al_hard    (alert_in[AL_HARDRST]),
        .al_rxstat  (alert_in[AL_RXSTAT]),
        .rx_cable   (rx_cable),
        .pe_hr_req  (pe_hr_req),
        .pe_cable   (pe_cable),
        .start      (trig_start),
        .from_local (trig_local),
        .is_cable   (trig_cable)
    );

    hrst_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_WAITPHY),
        .expired (wd_expired)
    );

    hrst_outdec #(
        .ALERT_W  (ALERT_W),
        .RXDET_W  (RXDET_W),
        .RXDET_EN (RXDET_EN)
    ) u_outdec (
        .state          (state),
        .busy           (busy),
        .msgid_clr      (msgid_clr),
        .tx_wr          (tx_wr),
        .pe_sent_ind    (pe_sent_ind),
        .pe_rcvd_ind    (pe_rcvd_ind),
        .alert_clr_wr   (alert_clr_wr),
        .alert_clr_mask (alert_clr_mask),
        .rxdet_wr       (rxdet_wr),
        .rxdet_val      (rxdet_val)
    );

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (trig_start) state_nx = S_LAYER;
            S_LAYER:    state_nx = rst_local ? S_REQTX : S_INDICATE;
            S_REQTX:    state_nx = S_WAITPHY;
            S_WAITPHY: begin
                if (phy_done)        state_nx = S_SENT;
                else if (wd_expired) state_nx = S_WAITPE;
            end
            S_SENT:     state_nx = S_WAITPE;
            S_INDICATE: state_nx = S_WAITPE;
            S_WAITPE:   if (pe_done) state_nx = S_CLEAR;
            S_CLEAR:    state_nx = S_RXEN;
            S_RXEN:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Origin and type of the sequence, captured at entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_local    <= 1'b0;
            rst_is_cable <= 1'b0;
        end else if (state == S_IDLE && trig_start) begin
            rst_local    <= trig_local;
            rst_is_cable <= trig_cable;
        end
    end

    // Error flag: set on watchdog abort, cleared by the next entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_err <= 1'b0;
        end else if (state == S_IDLE && trig_start) begin
            seq_err <= 1'b0;
        end else if (state == S_WAITPHY && !phy_done && wd_expired) begin
            seq_err <= 1'b1;
        end
    end

endmodule

// File: rtl/hrst_seq_chk.sv
// Property checker for hrst_seq, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset.
module hrst_seq_chk
    import hrst_pkg::*;
#(
    parameter int ALERT_W = 16,
    parameter int RXDET_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pe_done,
    input logic [ALERT_W-1:0] alert_in,
    input logic               busy,
    input logic               seq_err,
    input logic               rst_local,
    input logic               msgid_clr,
    input logic               tx_wr,
    input logic               pe_sent_ind,
    input logic               pe_rcvd_ind,
    input logic               alert_clr_wr,
    input logic [ALERT_W-1:0] alert_clr_mask,
    input logic               rxdet_wr,
    input logic [RXDET_W-1:0] rxdet_val
);

    assert_entry_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msgid_clr |-> busy);

    assert_local_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msgid_clr && rst_local) |=> tx_wr);

    assert_sent_needs_phy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pe_sent_ind |-> $past(alert_in[AL_TXOK] && alert_in[AL_TXFAIL]));

    assert_remote_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msgid_clr && !rst_local) |=> (pe_rcvd_ind && !tx_wr));

    assert_clear_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr_wr |-> $past(pe_done));

    assert_rxdet_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr_wr |=> (rxdet_wr && rxdet_val != '0));

    assert_clear_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr_wr |-> (alert_clr_mask[AL_HARDRST] && alert_clr_mask[AL_RXSTAT]
                          && alert_clr_mask[AL_TXOK] && alert_clr_mask[AL_TXFAIL]
                          && alert_clr_mask[AL_TXDISC] && alert_clr_mask[AL_RXFULL]
                          && $countones(alert_clr_mask) == 6));

    assert_err_no_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> (busy && !pe_sent_ind));

    assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxdet_wr |=> !busy);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msgid_clr, tx_wr, pe_sent_ind, pe_rcvd_ind, alert_clr_wr, rxdet_wr}));

endmodule

bind hrst_seq hrst_seq_chk #(.ALERT_W(ALERT_W), .RXDET_W(RXDET_W)) u_hrst_seq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pe_done        (pe_done),
    .alert_in       (alert_in),
    .busy           (busy),
    .seq_err        (seq_err),
    .rst_local      (rst_local),
    .msgid_clr      (msgid_clr),
    .tx_wr          (tx_wr),
    .pe_sent_ind    (pe_sent_ind),
    .pe_rcvd_ind    (pe_rcvd_ind),
    .alert_clr_wr   (alert_clr_wr),
    .alert_clr_mask (alert_clr_mask),
    .rxdet_wr       (rxdet_wr),
    .rxdet_val      (rxdet_val)
);

// File: tb/hrst_seq_bench.sv
// Bench for hrst_seq: behavioural reference model compared every cycle,
// plus scenario checks for the boundary cases.
module hrst_seq_bench;

    localparam int AW = 16;
    localparam int WD = 16;
    localparam logic [AW-1:0] EXP_MASK = 16'h0473;
    localparam logic [7:0]    EXP_RXD  = 8'h21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pe_hr_req = 1'b0, pe_cable = 1'b0, pe_done = 1'b0, rx_cable = 1'b0;
    logic [AW-1:0] alr = '0;
    logic          busy, seq_err, rst_local, rst_is_cable, msgid_clr, tx_wr;
    logic          pe_sent_ind, pe_rcvd_ind, alert_clr_wr, rxdet_wr;
    logic [AW-1:0] alert_clr_mask;
    logic [7:0]    rxdet_val;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    hrst_seq #(.ALERT_W(AW), .WDOG_CYC(WD), .RXDET_W(8), .RXDET_EN(8'h21)) u_hrst_seq (
        .clk(clk), .rst_n(rst_n), .pe_hr_req(pe_hr_req), .pe_cable(pe_cable),
        .pe_done(pe_done), .alert_in(alr), .rx_cable(rx_cable),
        .busy(busy), .seq_err(seq_err), .rst_local(rst_local), .rst_is_cable(rst_is_cable),
        .msgid_clr(msgid_clr), .tx_wr(tx_wr), .pe_sent_ind(pe_sent_ind),
        .pe_rcvd_ind(pe_rcvd_ind), .alert_clr_wr(alert_clr_wr),
        .alert_clr_mask(alert_clr_mask), .rxdet_wr(rxdet_wr), .rxdet_val(rxdet_val)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Alert register model: write-one-to-clear from the sequencer
    always @(posedge clk) if (alert_clr_wr) alr <= alr & ~alert_clr_mask;

    // Reference model: phase 0 idle, 1 layer reset, 2 send, 3 phy wait,
    // 4 sent, 5 received, 6 policy wait, 7 clear, 8 receiver on
    int m_ph = 0, m_wait = 0;
    bit m_err = 0, m_loc = 0, m_cab = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_err = 0; m_loc = 0; m_cab = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (alr[1] || (alr[0] && rx_cable) || pe_hr_req) begin
                        m_err = 0;
                        m_loc = !(alr[1] || (alr[0] && rx_cable));
                        m_cab = alr[1] ? 1'b0 : ((alr[0] && rx_cable) ? 1'b1 : pe_cable);
                        m_ph = 1;
                    end
                end
                1: m_ph = m_loc ? 2 : 5;
                2: begin m_ph = 3; m_wait = 0; end
                3: begin
                    m_wait++;
                    if (alr[4] && alr[6]) m_ph = 4;
                    else if (m_wait >= WD) begin m_ph = 6; m_err = 1; end
                end
                4, 5: m_ph = 6;
                6: if (pe_done) m_ph = 7;
                7: m_ph = 8;
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R9", "busy", busy, m_ph != 0);
            chk("R2", "msgid_clr", msgid_clr, m_ph == 1);
            chk("R3", "tx_wr", tx_wr, m_ph == 2);
            chk("R3", "rst_local", rst_local, m_loc);
            chk("R5", "rst_is_cable", rst_is_cable, m_cab);
            chk("R4", "pe_sent_ind", pe_sent_ind, m_ph == 4);
            chk("R5", "pe_rcvd_ind", pe_rcvd_ind, m_ph == 5);
            chk("R7", "alert_clr_wr", alert_clr_wr, m_ph == 7);
            chk("R7", "alert_clr_mask", alert_clr_mask, (m_ph == 7) ? EXP_MASK : '0);
            chk("R7", "rxdet_wr", rxdet_wr, m_ph == 8);
            chk("R7", "rxdet_val", rxdet_val, (m_ph == 8) ? EXP_RXD : 8'h00);
            chk("R8", "seq_err", seq_err, m_err);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req_pulse(input bit cab);
        @(negedge clk); pe_hr_req <= 1'b1; pe_cable <= cab;
        @(negedge clk); pe_hr_req <= 1'b0; pe_cable <= 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); pe_done <= 1'b1;
        @(negedge clk); pe_done <= 1'b0;
    endtask

    // which: 0 tx_wr, 1 pe_sent_ind, 2 rxdet_wr
    task automatic wait_for(input int which);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if ((which == 0 && tx_wr) || (which == 1 && pe_sent_ind) ||
                (which == 2 && rxdet_wr)) return;
        end
        chk("R2", "wait_for event", 0, 1);
    endtask

    task automatic finish_seq();
        done_pulse();
        wait_for(2);
        step(1);
    endtask

    initial begin
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        chk_en = 1'b1;
        step(1);
        // R1: reset state
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset strobes", {msgid_clr, tx_wr, pe_sent_ind, pe_rcvd_ind, alert_clr_wr, rxdet_wr}, 0);
        chk("R1", "reset mask", alert_clr_mask, 0);
        rst_n <= 1'b1;
        alr <= 16'h0100;
        step(2);

        // Local hard reset, partial completion first, early pe_done ignored
        req_pulse(1'b0);
        wait_for(0);
        chk("R3", "local flag with tx_wr", rst_local, 1);
        alr <= alr | 16'h0040;
        step(3);
        chk("R4", "one alert bit is not completion", {busy, pe_sent_ind}, 2'b10);
        done_pulse();
        step(1);
        chk("R6", "pe_done in phy wait ignored", {busy, alert_clr_wr}, 2'b10);
        alr <= alr | 16'h0030;
        wait_for(1);
        step(2);
        chk("R6", "still waiting for policy", {busy, alert_clr_wr}, 2'b10);
        done_pulse();
        wait_for(2);
        chk("R7", "alert image after clear", alr, 16'h0100);
        step(1);
        chk("R7", "idle after receiver write", busy, 0);

        // Local cable reset, completion in last watchdog cycle
        req_pulse(1'b1);
        wait_for(0);
        chk("R3", "cable type captured", rst_is_cable, 1);
        step(WD);
        alr <= alr | 16'h0050;
        step(1);
        chk("R8", "last-cycle completion succeeds", {pe_sent_ind, seq_err}, 2'b10);
        finish_seq();

        // Completion one cycle too late: watchdog abort
        req_pulse(1'b0);
        wait_for(0);
        step(WD + 1);
        alr <= alr | 16'h0050;
        chk("R8", "timeout sets error", {seq_err, pe_sent_ind, busy}, 3'b101);
        finish_seq();
        chk("R8", "error held after sequence", seq_err, 1);

        // Remote hard reset clears error; request while busy ignored
        alr <= alr | 16'h0002;
        step(2);
        chk("R5", "received hard reset indicated", {pe_rcvd_ind, rst_local, tx_wr}, 3'b100);
        chk("R8", "error cleared by new entry", seq_err, 0);
        req_pulse(1'b0);
        step(1);
        chk("R9", "request while busy ignored", {busy, msgid_clr, tx_wr}, 3'b100);
        finish_seq();
        step(2);
        chk("R9", "no late start from ignored request", busy, 0);

        // Cable status without its alert does nothing, then with it
        rx_cable <= 1'b1;
        step(3);
        chk("R2", "cable status alone ignored", busy, 0);
        alr <= alr | 16'h0001;
        step(2);
        chk("R5", "received cable reset", {pe_rcvd_ind, rst_is_cable}, 2'b11);
        finish_seq();
        rx_cable <= 1'b0;
        step(2);

        // Coincident request and received hard reset
        @(negedge clk); pe_hr_req <= 1'b1; alr <= alr | 16'h0002;
        @(negedge clk); pe_hr_req <= 1'b0;
        step(1);
        chk("R10", "hard alert beats request", {pe_rcvd_ind, rst_local, tx_wr}, 3'b100);
        finish_seq();

        // Coincident request and received cable reset
        @(negedge clk); pe_hr_req <= 1'b1; pe_cable <= 1'b0; rx_cable <= 1'b1; alr <= alr | 16'h0001;
        @(negedge clk); pe_hr_req <= 1'b0;
        step(1);
        chk("R10", "cable status beats request", {pe_rcvd_ind, rst_local, rst_is_cable}, 3'b101);
        finish_seq();
        rx_cable <= 1'b0;

        // Coincident hard alert and cable status
        @(negedge clk); rx_cable <= 1'b1; alr <= alr | 16'h0003;
        step(2);
        chk("R10", "hard alert beats cable status", {pe_rcvd_ind, rst_is_cable}, 2'b10);
        finish_seq();
        rx_cable <= 1'b0;
        step(3);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule